// File: doc/BRIEF.md
# Strided Memory Request Generator

This block produces a paced stream of memory read and write requests that sweep an address window in a blocked-strided pattern. Each request covers one transaction block. Consecutive blocks are issued back to back until a superblock has been covered. The walk then jumps forward so that successive superblocks sit one stride apart. When the walk passes the end of the window it returns to its origin, which is the window start plus a configured offset.

Several generators can share one window without overlapping. Give generator i an offset of i superblocks and give all of them a stride of N superblocks. Each generator then owns every N-th superblock.

A one-cycle `start` pulse checks and captures the configuration, then clears the address walk, the byte counter and the read/write sequence. Requests are offered with a valid/ready handshake. After each accepted request the block waits a fixed number of idle cycles before it offers the next one. A nonzero data cap ends the run and raises `done`. An illegal configuration raises `cfg_err` and issues nothing.

Top module: `strided_req_gen`

## Requirements
- R1: A legal `start` pulse makes the next cycle offer a request at `cfg_base + cfg_offset`. It also clears `done`, `cfg_err` and the transferred-byte count. A `start` that arrives during a run restarts that run.
- R2: After each accepted request the next address is the previous one plus the block size.
- R3: Track the bytes covered since the last superblock boundary. When the bytes issued since that boundary reach the superblock size, an extra `stride - superblock` is added to the next address.
- R4: When a candidate next address exceeds `cfg_end`, the next address is `cfg_base + cfg_offset` instead, and a new superblock begins.
- R5: A `start` is illegal when any of the following holds:
  - the block, superblock or stride size is zero;
  - the superblock is not a multiple of the block;
  - the offset is not a multiple of the superblock;
  - the stride is not a multiple of the superblock.

  An illegal `start` sets `cfg_err`, and no request is offered until a later legal `start` clears it.
- R6: The read/write flag comes from a 16-bit LFSR.
  - The LFSR is loaded with 16'hACE1 on `start` and steps once per accepted request.
  - Each step shifts left and inserts the XOR of bits 15, 13, 12 and 10 at bit 0.
  - A request is a read (`req_is_read`=1) when the current LFSR value modulo 100 is below `cfg_rd_pct`.
  - As a result, 0 gives only writes and 100 gives only reads.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_is_read` hold their values.
- R8: After an accepted request that does not end the run, `req_valid` stays low for exactly `cfg_gap` cycles. A gap of 0 allows back-to-back requests.
- R9: Each accepted request adds the block size to the byte count. When a nonzero `cfg_data_cap` is reached, `req_valid` drops and `done` rises, and both stay that way until the next `start`. A cap of 0 never ends the run.
- R10: After reset `req_valid`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: check and capture configuration, begin a run |
| cfg_base | input | ADDR_W | Window start address |
| cfg_end | input | ADDR_W | Highest address the walk may reach |
| cfg_offset | input | ADDR_W | Offset of the first address from the window start |
| cfg_blk | input | ADDR_W | Transaction block size in bytes |
| cfg_sblk | input | ADDR_W | Superblock size in bytes |
| cfg_stride | input | ADDR_W | Distance between superblock starts |
| cfg_rd_pct | input | 7 | Percentage of reads, 0 to 100 |
| cfg_data_cap | input | CNT_W | Bytes to transfer before done; 0 means unlimited |
| cfg_gap | input | GAP_W | Idle cycles after each accepted request |
| req_ready | input | 1 | Memory side accepts the offered request |
| req_valid | output | 1 | A request is offered |
| req_addr | output | ADDR_W | Request address |
| req_is_read | output | 1 | 1 for read, 0 for write |
| done | output | 1 | Data cap reached |
| cfg_err | output | 1 | Last start carried an illegal configuration |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=12 and GAP_W=4. With these widths a window a few hundred bytes wide wraps within a few dozen requests, so origin restarts appear several times per run. Small data caps end runs quickly, and gaps of 0, 1 and 5 cycles can each be measured exactly.

The runs cover three cases:
- superblocks of several blocks, and a superblock equal to one block, so that a jump follows every request;
- read percentages of 0, 50 and 100;
- a steady ready signal, and one that toggles to exercise the hold behaviour.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_GAP   = 2'd2,
    S_DONE  = 2'd3
  } srg_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/srg_cfg_check.sv
module srg_cfg_check #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] blk,
  input  logic [ADDR_W-1:0] sblk,
  input  logic [ADDR_W-1:0] stride,
  input  logic [ADDR_W-1:0] offset,
  output logic              legal
);
  logic nonzero;
  logic sb_fits, off_fits, st_fits;

  always_comb begin
    nonzero  = (blk != '0) && (sblk != '0) && (stride != '0);
    sb_fits  = 1'b0;
    off_fits = 1'b0;
    st_fits  = 1'b0;
    if (nonzero) begin
      sb_fits  = ((sblk % blk) == '0);
      off_fits = ((offset % sblk) == '0);
      st_fits  = ((stride % sblk) == '0);
    end
    legal = nonzero && sb_fits && off_fits && st_fits;
  end
endmodule

// File: rtl/srg_addr_walk.sv
module srg_addr_walk #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] blk,
  input  logic [ADDR_W-1:0] sblk,
  input  logic [ADDR_W-1:0] stride,
  input  logic [ADDR_W-1:0] lim,
  output logic [ADDR_W-1:0] addr
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] origin_q, blk_q, sblk_q, jump_q, lim_q, addr_q, pos_q;
  logic [SUM_W-1:0]  step, cand;
  logic [ADDR_W-1:0] pos_step, addr_nx, pos_nx;
  logic              sb_end, wrap;

  always_comb begin
    step     = {1'b0, addr_q} + {1'b0, blk_q};
    pos_step = pos_q + blk_q;
    sb_end   = (pos_step == sblk_q);
    cand     = sb_end ? (step + {1'b0, jump_q}) : step;
    wrap     = (cand > {1'b0, lim_q});
    addr_nx  = wrap ? origin_q : cand[ADDR_W-1:0];
    pos_nx   = (sb_end || wrap) ? '0 : pos_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      origin_q <= '0;
      blk_q    <= '0;
      sblk_q   <= '0;
      jump_q   <= '0;
      lim_q    <= '0;
      addr_q   <= '0;
      pos_q    <= '0;
    end else if (load) begin
      origin_q <= base + offset;
      addr_q   <= base + offset;
      blk_q    <= blk;
      sblk_q   <= sblk;
      jump_q   <= stride - sblk;
      lim_q    <= lim;
      pos_q    <= '0;
    end else if (adv) begin
      addr_q <= addr_nx;
      pos_q  <= pos_nx;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/srg_rw_pick.sv
module srg_rw_pick
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       adv,
  input  logic [6:0] pct,
  output logic       is_read
);
  logic [15:0] lfsr_q, lfsr_nx, seed_rem, nx_rem;
  logic [6:0]  pct_q;
  logic        rd_q;

  always_comb begin
    lfsr_nx  = lfsr_step(lfsr_q);
    seed_rem = LFSR_SEED % 16'd100;
    nx_rem   = lfsr_nx % 16'd100;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= LFSR_SEED;
      pct_q  <= '0;
      rd_q   <= 1'b0;
    end else if (load) begin
      lfsr_q <= LFSR_SEED;
      pct_q  <= pct;
      rd_q   <= (seed_rem < {9'd0, pct});
    end else if (adv) begin
      lfsr_q <= lfsr_nx;
      rd_q   <= (nx_rem < {9'd0, pct_q});
    end
  end

  assign is_read = rd_q;
endmodule

// File: rtl/strided_req_gen.sv
module strided_req_gen
  import srg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic [ADDR_W-1:0] cfg_blk,
  input  logic [ADDR_W-1:0] cfg_sblk,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic [6:0]        cfg_rd_pct,
  input  logic [CNT_W-1:0]  cfg_data_cap,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_is_read,
  output logic              done,
  output logic              cfg_err
);
  localparam int BSUM_W = CNT_W + 1;

  srg_state_e        state_q;
  logic              valid_q, done_q, err_q;
  logic [GAP_W-1:0]  gap_q, gap_cnt;
  logic [CNT_W-1:0]  cap_q, blk_q, bytes_q;
  logic [BSUM_W-1:0] bytes_nx;
  logic              cfg_ok, fire, load, adv, cap_hit;

  srg_cfg_check #(.ADDR_W(ADDR_W)) u_check (
    .blk    (cfg_blk),
    .sblk   (cfg_sblk),
    .stride (cfg_stride),
    .offset (cfg_offset),
    .legal  (cfg_ok)
  );

  assign fire = valid_q && req_ready;
  assign load = start && cfg_ok;
  assign adv  = fire && !start;

  srg_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .adv    (adv),
    .base   (cfg_base),
    .offset (cfg_offset),
    .blk    (cfg_blk),
    .sblk   (cfg_sblk),
    .stride (cfg_stride),
    .lim    (cfg_end),
    .addr   (req_addr)
  );

  srg_rw_pick u_rw (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .adv     (adv),
    .pct     (cfg_rd_pct),
    .is_read (req_is_read)
  );

  always_comb begin
    bytes_nx = {1'b0, bytes_q} + {1'b0, blk_q};
    cap_hit  = (cap_q != '0) && (bytes_nx >= {1'b0, cap_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      gap_q   <= '0;
      gap_cnt <= '0;
      cap_q   <= '0;
      blk_q   <= '0;
      bytes_q <= '0;
    end else if (start) begin
      err_q   <= !cfg_ok;
      done_q  <= 1'b0;
      bytes_q <= '0;
      gap_cnt <= '0;
      if (cfg_ok) begin
        state_q <= S_ISSUE;
        valid_q <= 1'b1;
        gap_q   <= cfg_gap;
        cap_q   <= cfg_data_cap;
        blk_q   <= CNT_W'(cfg_blk);
      end else begin
        state_q <= S_IDLE;
        valid_q <= 1'b0;
      end
    end else begin
      case (state_q)
        S_ISSUE: begin
          if (fire) begin
            bytes_q <= bytes_nx[CNT_W-1:0];
            if (cap_hit) begin
              state_q <= S_DONE;
              valid_q <= 1'b0;
              done_q  <= 1'b1;
            end else if (gap_q != '0) begin
              state_q <= S_GAP;
              valid_q <= 1'b0;
              gap_cnt <= gap_q;
            end
          end
        end
        S_GAP: begin
          if (gap_cnt <= GAP_W'(1)) begin
            state_q <= S_ISSUE;
            valid_q <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt - GAP_W'(1);
          end
        end
        default: begin
          valid_q <= 1'b0;
        end
      endcase
    end
  end

  assign req_valid = valid_q;
  assign done      = done_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/srg_props.sv
module srg_props #(
  parameter int ADDR_W = 32,
  parameter int GAP_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_read,
  input logic              done,
  input logic              cfg_err,
  input logic [GAP_W-1:0]  gap_q
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !start) |=>
      (req_valid && $stable(req_addr) && $stable(req_is_read)));

  p_gap_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !start && gap_q != '0) |=> !req_valid);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(req_valid && req_ready));

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!req_valid && !done));
endmodule

bind strided_req_gen srg_props #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_props (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_is_read (req_is_read),
  .done        (done),
  .cfg_err     (cfg_err),
  .gap_q       (gap_q)
);

// File: tb/sim_strided_req_gen.sv
`timescale 1ns/1ps
module sim_strided_req_gen;
  localparam int AW = 16;
  localparam int CW = 12;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_end = '0, cfg_offset = '0;
  logic [AW-1:0] cfg_blk = '0, cfg_sblk = '0, cfg_stride = '0;
  logic [6:0]    cfg_rd_pct = '0;
  logic [CW-1:0] cfg_data_cap = '0;
  logic [GW-1:0] cfg_gap = '0;
  logic          req_ready = 1'b0;
  logic          req_valid, req_is_read, done, cfg_err;
  logic [AW-1:0] req_addr;

  strided_req_gen #(.ADDR_W(AW), .CNT_W(CW), .GAP_W(GW)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_base(cfg_base), .cfg_end(cfg_end), .cfg_offset(cfg_offset),
    .cfg_blk(cfg_blk), .cfg_sblk(cfg_sblk), .cfg_stride(cfg_stride),
    .cfg_rd_pct(cfg_rd_pct), .cfg_data_cap(cfg_data_cap), .cfg_gap(cfg_gap),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_read(req_is_read), .done(done), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    addr;
    bit    rd;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    rdy_mode = 0;
  bit    rdy_hold = 1'b1;
  bit    mon_en = 1'b0;
  int    exp_gap = -1;
  bit    seen_hs = 1'b0;
  int    idle = 0;
  bit    hold_pend = 1'b0;
  int    h_addr = 0;
  bit    h_rd = 1'b0;
  int    hs_total = 0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // expected stream from the requirements R1..R4 and R6
  task automatic push_exp(input int base, input int lim, input int off,
                          input int blk, input int sblk, input int stride,
                          input int pct, input int n);
    int a, pos, origin;
    logic [15:0] s;
    string tg;
    origin = base + off;
    a = origin;
    pos = 0;
    s = 16'hACE1;
    tg = "R1";
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = a;
      e.rd = ((int'(s) % 100) < pct);
      e.tag = tg;
      expq.push_back(e);
      s = nxt_lfsr(s);
      a = a + blk;
      pos = pos + blk;
      tg = "R2";
      if (pos == sblk) begin
        a = a + stride - sblk;
        pos = 0;
        tg = "R3";
      end
      if (a > lim) begin
        a = origin;
        pos = 0;
        tg = "R4";
      end
    end
  endtask

  task automatic do_start(input int base, input int lim, input int off,
                          input int blk, input int sblk, input int stride,
                          input int pct, input int cap, input int gap);
    @(posedge clk);
    #1;
    rdy_hold = 1'b1;
    cfg_base = AW'(base); cfg_end = AW'(lim); cfg_offset = AW'(off);
    cfg_blk = AW'(blk); cfg_sblk = AW'(sblk); cfg_stride = AW'(stride);
    cfg_rd_pct = 7'(pct); cfg_data_cap = CW'(cap); cfg_gap = GW'(gap);
    start = 1'b1;
    expq.delete();
    @(posedge clk);
    #1;
    start = 1'b0;
    hold_pend = 1'b0;
    seen_hs = 1'b0;
    idle = 0;
    rdy_hold = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(done == 1'b1, req, "done raised", int'(done), 1);
    chk(req_valid == 1'b0, req, "valid low after cap", int'(req_valid), 0);
    chk(expq.size() == 0, req, "all expected requests issued", expq.size(), 0);
  endtask

  task automatic drain_then_hold();
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(posedge clk);
    #1;
    rdy_hold = 1'b1;
  endtask

  // ready driver
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    if (rdy_hold) req_ready = 1'b0;
    else if (rdy_mode == 0) req_ready = 1'b1;
    else req_ready = (cyc[0] ^ cyc[2]);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      if (hold_pend) begin
        hold_pend = 1'b0;
        chk(req_valid && int'(req_addr) == h_addr && req_is_read == h_rd,
            "R7", "request held while stalled", int'(req_addr), h_addr);
      end
      if (req_valid && req_ready) begin
        hs_total++;
        if (expq.size() == 0) begin
          chk(1'b0, "R9", "unexpected request", int'(req_addr), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(int'(req_addr) == e.addr, e.tag, "address", int'(req_addr), e.addr);
          chk(req_is_read == e.rd, "R6", "read flag", int'(req_is_read), int'(e.rd));
        end
        if (exp_gap >= 0 && seen_hs)
          chk(idle == exp_gap, "R8", "idle cycles between requests", idle, exp_gap);
        seen_hs = 1'b1;
        idle = 0;
      end else begin
        if (!req_valid) idle++;
        if (req_valid && !req_ready) begin
          hold_pend = 1'b1;
          h_addr = int'(req_addr);
          h_rd = req_is_read;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!req_valid, "R10", "valid after reset", int'(req_valid), 0);
    chk(!done, "R10", "done after reset", int'(done), 0);
    chk(!cfg_err, "R10", "cfg_err after reset", int'(cfg_err), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    mon_en = 1'b1;

    // Run A: multi-block superblocks, wrap, 50% reads, back-to-back (R1-R4 style walk)
    rdy_mode = 0;
    exp_gap = 0;
    do_start('h100, 'h1FF, 'h20, 8, 32, 64, 50, 40 * 8, 0);
    push_exp('h100, 'h1FF, 'h20, 8, 32, 64, 50, 40);
    wait_done("R9");

    // Run B: all writes, toggling ready exercises hold (R7), gap 2
    rdy_mode = 1;
    exp_gap = -1;
    do_start('h0, 'hFFF, 'h40, 16, 64, 128, 0, 12 * 16, 2);
    push_exp('h0, 'hFFF, 'h40, 16, 64, 128, 0, 12);
    wait_done("R9");

    // Run C: all reads, superblock equal to block, gap 5
    rdy_mode = 0;
    exp_gap = 5;
    do_start('h800, 'h83F, 8, 4, 4, 12, 100, 10 * 4, 5);
    push_exp('h800, 'h83F, 8, 4, 4, 12, 100, 10);
    wait_done("R9");

    // Illegal configurations (R5)
    exp_gap = -1;
    begin
      int base_hs;
      base_hs = hs_total;
      do_start('h0, 'hFF, 0, 16, 24, 48, 50, 0, 0);
      repeat (10) @(negedge clk);
      chk(cfg_err == 1'b1, "R5", "superblock not multiple of block", int'(cfg_err), 1);
      chk(req_valid == 1'b0, "R5", "no request on illegal config", int'(req_valid), 0);
      do_start('h0, 'hFF, 8, 8, 16, 32, 50, 0, 0);
      repeat (10) @(negedge clk);
      chk(cfg_err == 1'b1, "R5", "offset not multiple of superblock", int'(cfg_err), 1);
      do_start('h0, 'hFF, 0, 8, 16, 40, 50, 0, 0);
      repeat (10) @(negedge clk);
      chk(cfg_err == 1'b1, "R5", "stride not multiple of superblock", int'(cfg_err), 1);
      do_start('h0, 'hFF, 0, 0, 16, 32, 50, 0, 0);
      repeat (10) @(negedge clk);
      chk(cfg_err == 1'b1, "R5", "zero block size", int'(cfg_err), 1);
      chk(hs_total == base_hs, "R5", "handshakes during illegal runs", hs_total - base_hs, 0);
    end

    // Run D: unlimited cap, gap 1, legal start clears cfg_err (R1, R5, R9)
    exp_gap = 1;
    do_start('h200, 'h27F, 'h10, 8, 16, 32, 50, 0, 1);
    push_exp('h200, 'h27F, 'h10, 8, 16, 32, 50, 20);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R5", "cfg_err cleared by legal start", int'(cfg_err), 0);
    drain_then_hold();
    repeat (30) @(negedge clk);
    chk(done == 1'b0, "R9", "zero cap never finishes", int'(done), 0);
    chk(req_valid == 1'b1, "R7", "request still offered while ready low", int'(req_valid), 1);

    // Restart mid-run: walk and LFSR begin again from origin (R1)
    do_start('h200, 'h27F, 'h10, 8, 16, 32, 50, 6 * 8, 1);
    push_exp('h200, 'h27F, 'h10, 8, 16, 32, 50, 6);
    wait_done("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule